// File: doc/BRIEF.md
# Instruction-Cache Lookup Performance Counters

This block measures how well an instruction cache is doing. It keeps two event counters, one for lookups that hit and one for lookups that miss. The cache lookup logic feeds it single-cycle hit and miss pulses. It only raises these pulses when a lookup really happens. Fetches with the cache turned off, or fetches from RAM, never produce a pulse, so they are never counted. Software drives a start strobe to clear both counters and begin a measurement, and a stop strobe to freeze them. After a stop, both values stay on the outputs for software to read.

The block can leave out fetches made in interrupt context. It receives an interrupt-context flag and the interrupt-context caching-disable setting. When both are high, a hit or miss pulse changes neither counter. Each counter wraps to zero after its maximum value and sets its own sticky overflow flag. A flag stays set until software pulses that flag's clear input. A combined interrupt request goes high while any flag is set whose enable input is high.

Control is a two-state machine. In `CTR_IDLE` nothing counts. In `CTR_RUN` lookups are counted. The transition `GO` (IDLE to RUN, on start) and the transition `RESTART` (RUN to RUN, on start) both zero the counters. The transition `HALT` (RUN to IDLE, on stop without start) freezes them. The transition `STAY` keeps the current state when there is no command.

Top module: `lookup_perf_counters`

## Requirements
- R1: After reset, both counts read 0, both overflow flags read 0, the interrupt output is 0, and the block is idle. While idle, lookup pulses are not counted.
- R2: A start strobe sets both counts to 0 on the next cycle and enables counting from the cycle after the start.
- R3: A stop strobe without start freezes both counts on the following cycles, and they stay readable. A lookup in the same cycle as the stop is still counted.
- R4: While idle, before the first start or after a stop, hit and miss pulses leave both counts unchanged.
- R5: While running, each cycle with the hit input high adds exactly 1 to the hit count. Each cycle with the miss input high adds exactly 1 to the miss count. Cycles without a pulse leave the counts unchanged.
- R6: While the interrupt-context flag and the interrupt-caching-disable input are both high, hit and miss pulses change neither count. If only one of the two is high, the pulses are counted.
- R7: A counter that is incremented at its all-ones value reads 0 on the next cycle, and its overflow flag reads 1 on that same cycle.
- R8: An overflow flag stays 1 until its clear input is pulsed. A start strobe does not clear it. If an overflow and a clear arrive in the same cycle, the flag stays 1.
- R9: A start strobe takes priority over a lookup pulse and over a stop strobe in the same cycle. Both counts read 0 on the next cycle, and the block is running.
- R10: The interrupt output equals (hit flag AND hit enable) OR (miss flag AND miss enable) at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command strobe: zero the counts and run |
| stop_i | input | 1 | Stop command strobe: freeze the counts |
| hit_i | input | 1 | Lookup hit pulse |
| miss_i | input | 1 | Lookup miss pulse |
| irq_ctx_i | input | 1 | Current fetch is made in interrupt context |
| irq_cache_dis_i | input | 1 | Caching in interrupt context is disabled |
| hit_ovf_clr_i | input | 1 | Clear strobe for the hit overflow flag |
| miss_ovf_clr_i | input | 1 | Clear strobe for the miss overflow flag |
| hit_ovf_ie_i | input | 1 | Interrupt enable for the hit overflow flag |
| miss_ovf_ie_i | input | 1 | Interrupt enable for the miss overflow flag |
| hit_count_o | output | CNT_W | Hit count |
| miss_count_o | output | CNT_W | Miss count |
| hit_ovf_o | output | 1 | Sticky hit overflow flag |
| miss_ovf_o | output | 1 | Sticky miss overflow flag |
| irq_o | output | 1 | Combined overflow interrupt request |

## Verification
The counting path is tested with bursts of hits only, bursts of misses only, and alternating and simultaneous hit/miss pulses. These patterns show whether the two counters are truly independent or cross-coupled. Pulses are also sent while idle, after a stop, and in interrupt context with each setting of the disable input. These cases show whether the run state and the context gate are each applied on their own. The bench uses a narrow counter so that wrap-around is reached. It overflows each counter, clears one flag while the other overflows, and makes an overflow coincide with a clear, which shows whether setting a flag takes priority over clearing it. Start is also made to coincide with a lookup and with a stop, which shows the command priority.

// File: rtl/perfcnt_pkg.sv
package perfcnt_pkg;

    typedef enum logic [0:0] {
        CTR_IDLE = 1'b0,
        CTR_RUN  = 1'b1
    } ctr_state_e;

    typedef struct packed {
        logic zero;
        logic count_en;
    } ctr_ctl_t;

endpackage

// File: rtl/perfcnt_ctrl.sv
module perfcnt_ctrl
    import perfcnt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     stop_i,
    input  logic     irq_ctx_i,
    input  logic     irq_cache_dis_i,
    output ctr_ctl_t ctl_o,
    output logic     running_o
);

    ctr_state_e state_q, state_d;
    logic       ctx_blocked;

    assign ctx_blocked = irq_ctx_i & irq_cache_dis_i;

    // next-state logic: GO / RESTART on start, HALT on stop, STAY otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTR_IDLE: begin
                if (start_i) state_d = CTR_RUN;       // GO
            end
            CTR_RUN: begin
                if (start_i)     state_d = CTR_RUN;   // RESTART
                else if (stop_i) state_d = CTR_IDLE;  // HALT
            end
            default: state_d = CTR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTR_IDLE;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        ctl_o.zero     = start_i;
        ctl_o.count_en = 1'b0;
        unique case (state_q)
            CTR_IDLE: ctl_o.count_en = 1'b0;
            CTR_RUN:  ctl_o.count_en = !start_i && !ctx_blocked;
            default:  ctl_o.count_en = 1'b0;
        endcase
    end

    assign running_o = (state_q == CTR_RUN);

    a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> running_o);

    a_r3_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !running_o);

    a_r4_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !start_i) |=> !running_o);

endmodule

// File: rtl/perfcnt_event_ctr.sv
module perfcnt_event_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_i,
    input  logic             inc_i,
    input  logic             clr_flag_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             wrap;

    assign wrap = inc_i && !zero_i && (cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (zero_i) cnt_q <= '0;
        else if (inc_i)  cnt_q <= cnt_q + 1'b1;
    end

    // sticky flag: a new overflow wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ovf_q <= 1'b0;
        else if (wrap)       ovf_q <= 1'b1;
        else if (clr_flag_i) ovf_q <= 1'b0;
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !zero_i && cnt_o == CNT_MAX) |=> (cnt_o == '0 && ovf_o));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_flag_i) |=> ovf_o);

    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !zero_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !zero_i) |=> $stable(cnt_o));

    a_r9_zero: assert property (@(posedge clk) disable iff (!rst_n)
        zero_i |=> (cnt_o == '0));

endmodule

// File: rtl/lookup_perf_counters.sv
module lookup_perf_counters
    import perfcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             hit_i,
    input  logic             miss_i,
    input  logic             irq_ctx_i,
    input  logic             irq_cache_dis_i,
    input  logic             hit_ovf_clr_i,
    input  logic             miss_ovf_clr_i,
    input  logic             hit_ovf_ie_i,
    input  logic             miss_ovf_ie_i,
    output logic [CNT_W-1:0] hit_count_o,
    output logic [CNT_W-1:0] miss_count_o,
    output logic             hit_ovf_o,
    output logic             miss_ovf_o,
    output logic             irq_o
);

    localparam int NUM_CTR = 2;
    localparam int IDX_HIT = 0;
    localparam int IDX_MISS = 1;

    ctr_ctl_t         ctl;
    logic             running;
    logic [NUM_CTR-1:0] ev;
    logic [NUM_CTR-1:0] clr;
    logic [NUM_CTR-1:0] ovf;
    logic [NUM_CTR-1:0] ie;
    logic [CNT_W-1:0] cnt [NUM_CTR];

    assign ev  = {miss_i, hit_i};
    assign clr = {miss_ovf_clr_i, hit_ovf_clr_i};
    assign ie  = {miss_ovf_ie_i, hit_ovf_ie_i};

    perfcnt_ctrl u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .stop_i          (stop_i),
        .irq_ctx_i       (irq_ctx_i),
        .irq_cache_dis_i (irq_cache_dis_i),
        .ctl_o           (ctl),
        .running_o       (running)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        perfcnt_event_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk        (clk),
            .rst_n      (rst_n),
            .zero_i     (ctl.zero),
            .inc_i      (ctl.count_en && ev[g]),
            .clr_flag_i (clr[g]),
            .cnt_o      (cnt[g]),
            .ovf_o      (ovf[g])
        );
    end

    assign hit_count_o  = cnt[IDX_HIT];
    assign miss_count_o = cnt[IDX_MISS];
    assign hit_ovf_o    = ovf[IDX_HIT];
    assign miss_ovf_o   = ovf[IDX_MISS];
    assign irq_o        = |(ovf & ie);

    a_r6_ctx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && irq_ctx_i && irq_cache_dis_i) |=>
            ($stable(hit_count_o) && $stable(miss_count_o)));

    a_r4_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start_i) |=> ($stable(hit_count_o) && $stable(miss_count_o)));

    a_r8_start_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && hit_ovf_o && !hit_ovf_clr_i) |=> hit_ovf_o);

endmodule

// File: tb/lookup_perf_counters_test.sv
module lookup_perf_counters_test;

    localparam int W = 4;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, hit_i = 0, miss_i = 0;
    logic irq_ctx_i = 0, irq_cache_dis_i = 0;
    logic hit_ovf_clr_i = 0, miss_ovf_clr_i = 0;
    logic hit_ovf_ie_i = 0, miss_ovf_ie_i = 0;
    logic [W-1:0] hit_count_o, miss_count_o;
    logic hit_ovf_o, miss_ovf_o, irq_o;

    int tests = 0;
    int fails = 0;

    // reference model state
    int  m_hit = 0, m_miss = 0;
    bit  m_hovf = 0, m_movf = 0, m_run = 0;

    always #5 clk = ~clk;

    lookup_perf_counters #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .hit_i(hit_i), .miss_i(miss_i), .irq_ctx_i(irq_ctx_i),
        .irq_cache_dis_i(irq_cache_dis_i), .hit_ovf_clr_i(hit_ovf_clr_i),
        .miss_ovf_clr_i(miss_ovf_clr_i), .hit_ovf_ie_i(hit_ovf_ie_i),
        .miss_ovf_ie_i(miss_ovf_ie_i), .hit_count_o(hit_count_o),
        .miss_count_o(miss_count_o), .hit_ovf_o(hit_ovf_o),
        .miss_ovf_o(miss_ovf_o), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        bit exp_irq;
        exp_irq = (m_hovf && hit_ovf_ie_i) || (m_movf && miss_ovf_ie_i);
        check(int'(hit_count_o) == m_hit, tag, "hit_count", int'(hit_count_o), m_hit);
        check(int'(miss_count_o) == m_miss, tag, "miss_count", int'(miss_count_o), m_miss);
        check(hit_ovf_o == m_hovf, tag, "hit_ovf", int'(hit_ovf_o), int'(m_hovf));
        check(miss_ovf_o == m_movf, tag, "miss_ovf", int'(miss_ovf_o), int'(m_movf));
        check(irq_o == exp_irq, "R10", "irq", int'(irq_o), int'(exp_irq));
    endtask

    // one clock: drive inputs, advance model at the edge, compare after it
    task automatic step(input bit h, input bit m, input bit ctx, input bit dis,
                        input bit st, input bit sp, input bit hc, input bit mc,
                        input string tag);
        bit hset, mset;
        hit_i = h; miss_i = m; irq_ctx_i = ctx; irq_cache_dis_i = dis;
        start_i = st; stop_i = sp; hit_ovf_clr_i = hc; miss_ovf_clr_i = mc;
        @(posedge clk);
        hset = 0; mset = 0;
        if (st) begin
            m_hit = 0; m_miss = 0; m_run = 1;
        end else begin
            if (m_run && !(ctx && dis)) begin
                if (h) begin
                    if (m_hit == MAXV) begin m_hit = 0; hset = 1; end
                    else m_hit++;
                end
                if (m) begin
                    if (m_miss == MAXV) begin m_miss = 0; mset = 1; end
                    else m_miss++;
                end
            end
            if (sp) m_run = 0;
        end
        m_hovf = hset || (m_hovf && !hc);
        m_movf = mset || (m_movf && !mc);
        #2;
        compare_all(tag);
        hit_i = 0; miss_i = 0; start_i = 0; stop_i = 0;
        hit_ovf_clr_i = 0; miss_ovf_clr_i = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #2;
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        // R4: pulses before any start
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0, 0, 0, 0, "R4");
        // R2: start
        step(0, 0, 0, 0, 1, 0, 0, 0, "R2");
        // R5: hit-only, miss-only, alternating, simultaneous, gaps
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R5");
        for (int i = 0; i < 2; i++) step(0, 1, 0, 0, 0, 0, 0, 0, "R5");
        for (int i = 0; i < 4; i++) step(i[0], !i[0], 0, 0, 0, 0, 0, 0, "R5");
        step(1, 1, 0, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R5");
        // R6: interrupt context gating
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, 0, 0, 0, "R6");
        step(1, 0, 1, 0, 0, 0, 0, 0, "R6");
        step(0, 1, 0, 1, 0, 0, 0, 0, "R6");
        // R3: stop with a lookup in the same cycle, then frozen
        step(1, 0, 0, 0, 0, 1, 0, 0, "R3");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 0, 0, 0, "R3");
        // R9: start with lookup, start with stop
        step(1, 1, 0, 0, 1, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 1, 1, 0, 0, "R9");
        step(1, 1, 0, 0, 0, 0, 0, 0, "R9");
        // R7: wrap hit counter, then miss counter
        hit_ovf_ie_i = 1;
        for (int i = 0; i < MAXV + 2; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R7");
        for (int i = 0; i < MAXV + 1; i++) step(0, 1, 0, 0, 0, 0, 0, 0, "R7");
        // R8: start does not clear flags; clear works; set beats clear
        step(0, 0, 0, 0, 1, 0, 0, 0, "R8");
        miss_ovf_ie_i = 1;
        step(0, 0, 0, 0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
        miss_ovf_ie_i = 0;
        step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
        for (int i = 0; i < MAXV; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(1, 0, 0, 0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R8");
        hit_ovf_ie_i = 0;
        step(0, 0, 0, 0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R8");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule